// File: doc/BRIEF.md
# Core Store Buffer with Load Forwarding

This block sits between a processor core and its private data cache. A store from the core is written into a small first-in first-out buffer and the core continues at once, even when the cache does not yet hold write permission for the target line. The buffer hands its oldest entry to the cache through a drain port. The cache raises the grant only when it can commit the write. While the line's ownership is still being fetched, the grant stays low and the head entry waits.

Loads from the same core check the buffered stores for the same word. When the youngest overlapping store covers every byte that the load asks for, the load takes its data from the buffer. When that store covers only some of the bytes, the load stalls until the store has drained. When nothing overlaps, the load is released to the cache. A fence holds back every later load and store until the buffer is empty. An atomic read-modify-write also waits for the buffer to empty, and then goes to the cache as one indivisible drain-port operation.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty, `dr_valid` is low and `st_ready` is high.
- R2: A store is accepted (`st_valid` and `st_ready` high at a clock edge) regardless of the state of `dr_grant`.
- R3: When the buffer holds DEPTH entries, `st_ready` is low, and the store is held back even in a cycle where the head drains.
- R4: The drain port always presents the oldest buffered store (address, byte enables, data) with `dr_valid` high and `dr_amo` low, and removes it at a clock edge where `dr_grant` is high. Stores therefore leave in the order they were accepted.
- R5: While `dr_grant` is low, the head entry stays on the drain port unchanged.
- R6: A load is forwarded (`ld_ready` and `ld_fwd` high) when the youngest buffered store to the same word address with a non-zero byte-enable overlap sets every byte bit of `ld_be`.
- R7: When several buffered stores overlap a load, `ld_data` comes from the youngest of them. Byte lane b of `ld_data` is bits [8b+7:8b], it is copied when `ld_be[b]` is set, and it is zero otherwise.
- R8: When the youngest overlapping store lacks any byte that the load requests, `ld_ready` is low.
- R9: A load that overlaps no buffered store has `ld_ready` high, `ld_fwd` low and `ld_data` zero.
- R10: A `fence_valid` pulse arriving while the buffer is not empty holds `st_ready` and `ld_ready` low until the buffer is empty. A fence that arrives while the buffer is empty has no effect.
- R11: While `amo_valid` is high, stores and loads are blocked. Once the buffer is empty, the drain port shows `dr_amo` high with `amo_addr`, all byte enables set and `amo_data`. `amo_done` is high in the cycle in which that operation is granted.
- R12: A load in the same cycle as an accepted store is treated as older than that store and is not forwarded from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core store request |
| st_addr | input | 16 | Store word address |
| st_be | input | 4 | Store byte enables |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store accepted this cycle when high |
| ld_valid | input | 1 | Core load request |
| ld_addr | input | 16 | Load word address |
| ld_be | input | 4 | Load byte enables |
| ld_ready | output | 1 | Load may proceed this cycle |
| ld_fwd | output | 1 | Load data is supplied by the buffer |
| ld_data | output | 32 | Forwarded load data, masked to ld_be |
| fence_valid | input | 1 | Fence pulse from the core |
| amo_valid | input | 1 | Atomic request, held until amo_done |
| amo_addr | input | 16 | Atomic word address |
| amo_data | input | 32 | Atomic operand |
| amo_done | output | 1 | Atomic taken by the cache this cycle |
| dr_valid | output | 1 | Drain request to the cache |
| dr_amo | output | 1 | Drain request is the atomic operation |
| dr_addr | output | 16 | Drain word address |
| dr_be | output | 4 | Drain byte enables |
| dr_data | output | 32 | Drain data |
| dr_grant | input | 1 | Cache commits the presented request; low while ownership is pending |

## Verification
Every handshake output (`st_ready`, `ld_ready`, `ld_fwd`, `ld_data`, the drain port and `amo_done`) depends combinationally on the current inputs and on state registered at the previous edge. A result is therefore due in the same cycle as its stimulus, and state changes become visible one clock edge later. The bench drives inputs at the falling edge and samples every output a quarter period later. It then updates a queue-based reference model at the rising edge from the handshakes that the model itself predicted. The checks keep to that timing: a store accepted at edge N can be forwarded or drained from cycle N+1 on, and a same-cycle load must not see it.

// File: rtl/sb_pkg.sv
package sb_pkg;

    parameter int SB_AW = 16;
    parameter int SB_DW = 32;
    parameter int SB_BW = SB_DW / 8;

    typedef struct packed {
        logic [SB_AW-1:0] addr;
        logic [SB_BW-1:0] be;
        logic [SB_DW-1:0] data;
    } sb_entry_t;

    function automatic logic [SB_DW-1:0] be_mask(input logic [SB_BW-1:0] be);
        logic [SB_DW-1:0] m;
        for (int b = 0; b < SB_BW; b++) begin
            m[b*8 +: 8] = {8{be[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/sb_fifo.sv
module sb_fifo
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push,
    input  sb_entry_t             push_ent,
    input  logic                  pop,
    output sb_entry_t [DEPTH-1:0] ents_age,
    output logic [CW-1:0]         count
);

    sb_entry_t      mem [DEPTH];
    logic [PW-1:0]  head_q;
    logic [PW-1:0]  tail_q;
    logic [CW-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                mem[tail_q] <= push_ent;
                tail_q      <= tail_q + 1'b1;
            end
            if (pop) begin
                head_q <= head_q + 1'b1;
            end
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // Index 0 is the oldest entry, higher indices are younger.
    for (genvar i = 0; i < DEPTH; i++) begin : g_age
        assign ents_age[i] = mem[head_q + PW'(i)];
    end

    assign count = cnt_q;

    // R3
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/sb_fwd.sv
module sb_fwd
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  sb_entry_t [DEPTH-1:0] ents_age,
    input  logic [CW-1:0]         count,
    input  logic [SB_AW-1:0]      ld_addr,
    input  logic [SB_BW-1:0]      ld_be,
    output logic                  overlap,
    output logic                  covered,
    output logic [SB_DW-1:0]      fwd_data
);

    // Scan oldest to youngest; a later match overrides, so the youngest wins.
    always_comb begin
        overlap  = 1'b0;
        covered  = 1'b0;
        fwd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CW'(i) < count) && (ents_age[i].addr == ld_addr) &&
                ((ents_age[i].be & ld_be) != '0)) begin
                overlap  = 1'b1;
                covered  = ((ents_age[i].be & ld_be) == ld_be);
                fwd_data = ents_age[i].data & be_mask(ld_be);
            end
        end
    end

endmodule

// File: rtl/store_buffer.sv
module store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    input  logic [SB_AW-1:0] st_addr,
    input  logic [SB_BW-1:0] st_be,
    input  logic [SB_DW-1:0] st_data,
    output logic             st_ready,
    input  logic             ld_valid,
    input  logic [SB_AW-1:0] ld_addr,
    input  logic [SB_BW-1:0] ld_be,
    output logic             ld_ready,
    output logic             ld_fwd,
    output logic [SB_DW-1:0] ld_data,
    input  logic             fence_valid,
    input  logic             amo_valid,
    input  logic [SB_AW-1:0] amo_addr,
    input  logic [SB_DW-1:0] amo_data,
    output logic             amo_done,
    output logic             dr_valid,
    output logic             dr_amo,
    output logic [SB_AW-1:0] dr_addr,
    output logic [SB_BW-1:0] dr_be,
    output logic [SB_DW-1:0] dr_data,
    input  logic             dr_grant
);

    sb_entry_t [DEPTH-1:0] ents_age;
    logic [CW-1:0]         count;
    logic [CW-1:0]         cnt_nxt;
    logic                  empty, full, push, pop;
    logic                  fence_pend_q, fence_hold, block;
    logic                  overlap, covered;
    logic [SB_DW-1:0]      fwd_data;
    sb_entry_t             new_ent;

    assign new_ent = '{addr: st_addr, be: st_be, data: st_data};

    sb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (new_ent),
        .pop      (pop),
        .ents_age (ents_age),
        .count    (count)
    );

    sb_fwd #(.DEPTH(DEPTH)) u_fwd (
        .ents_age (ents_age),
        .count    (count),
        .ld_addr  (ld_addr),
        .ld_be    (ld_be),
        .overlap  (overlap),
        .covered  (covered),
        .fwd_data (fwd_data)
    );

    assign empty      = (count == '0);
    assign full       = (count == CW'(DEPTH));
    assign fence_hold = (fence_valid | fence_pend_q) & ~empty;
    assign block      = amo_valid | fence_hold;

    assign st_ready = ~block & ~full;
    assign push     = st_valid & st_ready;
    assign pop      = ~empty & dr_grant;
    assign cnt_nxt  = count + CW'(push) - CW'(pop);

    // Fence stays armed until the buffer has emptied; no store can enter meanwhile.
    always_ff @(posedge clk) begin
        if (rst) fence_pend_q <= 1'b0;
        else     fence_pend_q <= fence_hold & (cnt_nxt != '0);
    end

    assign dr_valid = ~empty | amo_valid;
    assign dr_amo   = empty & amo_valid;
    assign dr_addr  = empty ? amo_addr : ents_age[0].addr;
    assign dr_be    = empty ? {SB_BW{1'b1}} : ents_age[0].be;
    assign dr_data  = empty ? amo_data : ents_age[0].data;
    assign amo_done = dr_amo & dr_grant;

    assign ld_ready = ld_valid & ~block & ~(overlap & ~covered);
    assign ld_fwd   = ld_ready & overlap;
    assign ld_data  = ld_fwd ? fwd_data : '0;

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dr_valid && !dr_amo && !dr_grant) |=> (dr_valid && !dr_amo &&
            $stable(dr_addr) && $stable(dr_be) && $stable(dr_data)));

    // R10
    fence_block_chk: assert property (@(posedge clk) disable iff (rst)
        (fence_valid && count > CW'(1)) |=> (!st_ready && !ld_ready));

    // R11
    amo_block_chk: assert property (@(posedge clk) disable iff (rst)
        amo_valid |-> !st_ready);

    // R11
    amo_after_store_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> !dr_amo);

    // R9
    nofwd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_ready && !ld_fwd) |-> (ld_data == '0));

endmodule

// File: tb/store_buffer_tb.sv
module store_buffer_tb;
    import sb_pkg::*;

    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst;
    logic st_valid, ld_valid, fence_valid, amo_valid, dr_grant;
    logic [SB_AW-1:0] st_addr, ld_addr, amo_addr;
    logic [SB_BW-1:0] st_be, ld_be;
    logic [SB_DW-1:0] st_data, amo_data;
    logic st_ready, ld_ready, ld_fwd, amo_done, dr_valid, dr_amo;
    logic [SB_DW-1:0] ld_data, dr_data;
    logic [SB_AW-1:0] dr_addr;
    logic [SB_BW-1:0] dr_be;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    sb_entry_t q[$];
    bit m_fpend;

    logic s_st_ready, s_ld_ready, s_ld_fwd, s_dr_valid;
    logic [SB_DW-1:0] s_ld_data, s_dr_data;
    logic [SB_AW-1:0] s_dr_addr;

    always #10 clk = ~clk;

    store_buffer #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_be(st_be), .st_data(st_data),
        .st_ready(st_ready),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
        .ld_ready(ld_ready), .ld_fwd(ld_fwd), .ld_data(ld_data),
        .fence_valid(fence_valid), .amo_valid(amo_valid), .amo_addr(amo_addr),
        .amo_data(amo_data), .amo_done(amo_done),
        .dr_valid(dr_valid), .dr_amo(dr_amo), .dr_addr(dr_addr), .dr_be(dr_be),
        .dr_data(dr_data), .dr_grant(dr_grant)
    );

    function automatic logic [SB_DW-1:0] lane_mask(input logic [SB_BW-1:0] be);
        logic [SB_DW-1:0] m = '0;
        for (int b = 0; b < SB_BW; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        st_valid = 0; ld_valid = 0; fence_valid = 0; amo_valid = 0; dr_grant = 0;
        st_addr = '0; st_be = '0; st_data = '0; ld_addr = '0; ld_be = '0;
        amo_addr = '0; amo_data = '0;
    endtask

    // One cycle: inputs already set after a falling edge; compare, then update model.
    task automatic tick();
        int n, hj;
        bit emp, blk, e_st, e_ldr, e_fwd, hit, cov, popm, pushm;
        logic [SB_DW-1:0] e_ld;
        #5;
        n = q.size();
        emp = (n == 0);
        blk = amo_valid || ((fence_valid || m_fpend) && !emp);
        e_st = !blk && (n < DEPTH);
        hit = 0; cov = 0; hj = 0;
        for (int j = n - 1; j >= 0; j--) begin
            if (q[j].addr == ld_addr && (q[j].be & ld_be) != 0) begin
                hit = 1; cov = ((q[j].be & ld_be) == ld_be); hj = j;
                break;
            end
        end
        e_ldr = ld_valid && !blk && !(hit && !cov);
        e_fwd = e_ldr && hit;
        e_ld  = e_fwd ? (q[hj].data & lane_mask(ld_be)) : '0;
        s_st_ready = st_ready; s_ld_ready = ld_ready; s_ld_fwd = ld_fwd;
        s_ld_data = ld_data; s_dr_valid = dr_valid; s_dr_addr = dr_addr; s_dr_data = dr_data;
        chk(st_ready, e_st, "R3 st_ready");
        chk(ld_ready, e_ldr, "R8 ld_ready");
        chk(ld_fwd, e_fwd, "R6 ld_fwd");
        chk(ld_data, e_ld, "R7 ld_data");
        chk(dr_valid, !emp || amo_valid, "R4 dr_valid");
        chk(dr_amo, emp && amo_valid, "R11 dr_amo");
        chk(amo_done, emp && amo_valid && dr_grant, "R11 amo_done");
        if (!emp) begin
            chk(dr_addr, q[0].addr, "R4 dr_addr");
            chk(dr_be, q[0].be, "R4 dr_be");
            chk(dr_data, q[0].data, "R4 dr_data");
        end else if (amo_valid) begin
            chk(dr_addr, amo_addr, "R11 dr_addr");
            chk(dr_be, {SB_BW{1'b1}}, "R11 dr_be");
            chk(dr_data, amo_data, "R11 dr_data");
        end
        popm = !emp && dr_grant;
        pushm = st_valid && e_st;
        @(posedge clk);
        m_fpend = ((fence_valid || m_fpend) && !emp) && ((n - popm + pushm) != 0);
        if (popm) void'(q.pop_front());
        if (pushm) q.push_back('{addr: st_addr, be: st_be, data: st_data});
        @(negedge clk);
        idle();
    endtask

    task automatic store(input int a, input logic [3:0] be, input logic [31:0] d);
        st_valid = 1; st_addr = SB_AW'(a); st_be = be; st_data = d;
    endtask

    task automatic load(input int a, input logic [3:0] be);
        ld_valid = 1; ld_addr = SB_AW'(a); ld_be = be;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [SB_AW-1:0] held;
        idle();
        m_fpend = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: empty after reset
        tick();
        chk(s_dr_valid, 1'b0, "R1 dr_valid after reset");
        chk(s_st_ready, 1'b1, "R1 st_ready after reset");

        // R12: same-cycle store and load, then forwarding next cycle
        store(5, 4'hF, 32'hAABBCCDD); load(5, 4'hF); tick();
        chk(s_ld_fwd, 1'b0, "R12 same-cycle load not forwarded");
        load(5, 4'h3); tick();
        chk(s_ld_fwd, 1'b1, "R6 forwarded next cycle");
        chk(s_ld_data, 32'h0000CCDD, "R7 masked data");

        // R2: stores accepted with grant low; youngest match wins
        store(5, 4'h3, 32'h11112222); tick();
        chk(s_st_ready, 1'b1, "R2 accepted without grant");
        load(5, 4'h1); tick();
        chk(s_ld_data, 32'h00000022, "R7 youngest match");
        load(5, 4'hF); tick();
        chk(s_ld_ready, 1'b0, "R8 partial overlap stall");
        load(9, 4'hF); tick();
        chk(s_ld_ready, 1'b1, "R9 no overlap ready");
        chk(s_ld_fwd, 1'b0, "R9 no overlap not forwarded");
        store(6, 4'hF, 32'h3); tick();
        store(7, 4'hF, 32'h4); tick();
        store(8, 4'hF, 32'h5); dr_grant = 1; tick();
        chk(s_st_ready, 1'b0, "R3 full blocks even while draining");

        // R5: head stable while grant low
        tick(); held = s_dr_addr; tick();
        chk(s_dr_addr, held, "R5 head held");

        // R10: fence blocks until empty
        fence_valid = 1; dr_grant = 1; tick();
        store(1, 4'hF, 32'h9); load(9, 4'hF); tick();
        chk(s_st_ready, 1'b0, "R10 store blocked by fence");
        chk(s_ld_ready, 1'b0, "R10 load blocked by fence");
        dr_grant = 1; tick();
        dr_grant = 1; tick();
        store(1, 4'hF, 32'h9); tick();
        chk(s_st_ready, 1'b1, "R10 released when empty");

        // R11: atomic waits for drain, then issues
        store(2, 4'hF, 32'h7); tick();
        amo_valid = 1; amo_addr = 16'h40; amo_data = 32'h1; dr_grant = 1; tick();
        amo_valid = 1; amo_addr = 16'h40; amo_data = 32'h1; dr_grant = 1; tick();
        amo_valid = 1; amo_addr = 16'h40; amo_data = 32'h1; dr_grant = 1; tick();
        chk(s_dr_addr, 16'h40, "R11 atomic on drain port");

        // Mixed traffic against the reference model
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 1) == 1) store($urandom_range(0, 3), 4'($urandom_range(1, 15)), $urandom);
            if ($urandom_range(0, 1) == 1) load($urandom_range(0, 3), 4'($urandom_range(1, 15)));
            fence_valid = ($urandom_range(0, 19) == 0);
            amo_valid = ($urandom_range(0, 14) == 0);
            amo_addr = 16'($urandom_range(0, 3)); amo_data = $urandom;
            dr_grant = ($urandom_range(0, 2) != 0);
            tick();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule